// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals of an incremental encoder, plus an optional index pulse, into a signed position count. A free-running system clock samples all three pins. None of the pins ever clocks anything. Each pin passes through a two-flop synchronizer. An optional stability filter follows the synchronizer and suppresses contact bounce from mechanical encoders.

A four-state Gray-code tracker compares each conditioned {A,B} sample with the previous one. It steps the count up or down on every legal edge, which gives four counts per encoder cycle. When both phases move in one sample step, the count is left alone and the move is flagged as an invalid transition.

Four events are held in a sticky status register: counter wrap past the maximum, counter wrap past the minimum, index reset, and invalid transition. An interrupt line is high while any of them is pending. A small read port returns either the count or the status, and a read strobe on the status address clears it. For lossless counting, the sampling clock should run at least about ten times the phase edge rate.

Top module: `quad_decoder`

## Requirements
- R1: After a synchronous reset, the count reads 0, the status reads 0 and `irq` is low.
- R2: The pair {A,B} moving through 00, 01, 11, 10 and back to 00 adds one to the count on each move.
- R3: The same pairs taken in the opposite order subtract one from the count on each move.
- R4: A sample step in which A and B both change leaves the count unchanged and sets status bit 3 (invalid transition).
- R5: An increment from the largest signed value wraps the count to the smallest signed value and sets status bit 0 (overflow).
- R6: A decrement from the smallest signed value wraps the count to the largest signed value and sets status bit 1 (underflow).
- R7: With `idx_en` high, a rising edge of the conditioned index clears the count to 0 and sets status bit 2. With `idx_en` low, the index has no effect on the count or the status.
- R8: With `filt_en` high, a new level on any pin is accepted only after it has been stable for 3 consecutive samples. Shorter pulses are dropped. With `filt_en` low, the synchronized level is used directly, so a 2-cycle pulse on both phases is seen as invalid transitions.
- R9: Status bits stay set until a clear strobe, which is `rd_en` high with `rd_addr` = 1. An event arriving in the same cycle as the clear stays set.
- R10: `irq` is high whenever any status bit is set.
- R11: `rd_addr` = 0 returns the count in two's complement. `rd_addr` = 1 returns the status in bits [3:0], zero-extended.
- R12: After reset, the first conditioned sample loads the previous-state register. Starting with both phases high therefore produces no count and no invalid event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Encoder phase A, asynchronous |
| b_in | input | 1 | Encoder phase B, asynchronous |
| idx_in | input | 1 | Encoder index pulse, asynchronous |
| idx_en | input | 1 | Enables count clearing by the index |
| filt_en | input | 1 | Enables the stability filter |
| rd_en | input | 1 | Read strobe; clears status when `rd_addr` is 1 |
| rd_addr | input | 1 | 0 selects the count, 1 selects the status |
| rd_data | output | CNT_W | Read data, combinational from `rd_addr` |
| irq | output | 1 | High while any status event is pending |

## Verification
The bench builds the decoder with a 4-bit counter and keeps the default 2-stage synchronizer and 3-sample filter. With a 4-bit counter, a sweep of only a few dozen Gray-code steps crosses both wrap points more than once, in both directions. Every sweep runs once with the filter on and once with it off. The count is compared after each step with a signed model that wraps at +7 and -8. Pulses of two and three samples are applied to probe the filter threshold from both sides.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int ST_W   = 4;
  localparam int ST_OVF = 0;
  localparam int ST_UNF = 1;
  localparam int ST_IDX = 2;
  localparam int ST_BAD = 3;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_DN   = 2'd2,
    MV_BAD  = 2'd3
  } move_e;

  // Position of an {A,B} pair on the forward cycle 00,01,11,10.
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

  // Classify a move between two consecutive samples.
  function automatic move_e classify(input logic [1:0] prev, input logic [1:0] cur);
    logic [1:0] d;
    d = gray_pos(cur) - gray_pos(prev);
    case (d)
      2'd0:    return MV_NONE;
      2'd1:    return MV_UP;
      2'd3:    return MV_DN;
      default: return MV_BAD;
    endcase
  endfunction

endpackage

// File: rtl/qdec_input_cond.sv
module qdec_input_cond #(
  parameter int N        = 3,
  parameter int SYNC     = 2,
  parameter int FILT_LEN = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         filt_en,
  input  logic [N-1:0] raw,
  output logic [N-1:0] clean,
  output logic         valid
);
  localparam int WARM_W = $clog2(SYNC + 2);
  localparam int FW     = $clog2(FILT_LEN + 1);
  localparam logic [WARM_W-1:0] WARM_END = WARM_W'(SYNC + 1);

  logic [N-1:0]      sync_q [SYNC];
  logic [WARM_W-1:0] warm_q;
  logic [N-1:0]      s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst)                  warm_q <= '0;
    else if (warm_q != WARM_END) warm_q <= warm_q + 1'b1;
  end

  assign valid = (warm_q == WARM_END);

  for (genvar g = 0; g < N; g++) begin : g_filt
    logic [FW-1:0] run_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        clean[g] <= 1'b0;
        run_q    <= '0;
      end else if (!valid || !filt_en) begin
        clean[g] <= s[g];
        run_q    <= '0;
      end else if (s[g] == clean[g]) begin
        run_q    <= '0;
      end else if (run_q == FW'(FILT_LEN - 1)) begin
        clean[g] <= s[g];
        run_q    <= '0;
      end else begin
        run_q    <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/qdec_tracker.sv
module qdec_tracker
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  logic [1:0] ab,
  input  logic       idx,
  input  logic       idx_en,
  output logic       step_up,
  output logic       step_dn,
  output logic       ev_bad,
  output logic       ev_idx
);
  logic       primed_q;
  logic [1:0] prev_ab_q;
  logic       prev_idx_q;
  logic       live;
  move_e      mv;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q   <= 1'b0;
      prev_ab_q  <= 2'b00;
      prev_idx_q <= 1'b0;
    end else if (valid) begin
      primed_q   <= 1'b1;
      prev_ab_q  <= ab;
      prev_idx_q <= idx;
    end
  end

  assign live    = valid && primed_q;
  assign mv      = classify(prev_ab_q, ab);
  assign step_up = live && (mv == MV_UP);
  assign step_dn = live && (mv == MV_DN);
  assign ev_bad  = live && (mv == MV_BAD);
  assign ev_idx  = live && idx_en && idx && !prev_idx_q;

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         clr_idx,
  output logic [W-1:0] count,
  output logic         ev_ovf,
  output logic         ev_unf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] next_count(
    input logic [W-1:0] cur, input logic up, input logic dn, input logic clr);
    if (clr)     return '0;
    else if (up) return cur + W'(1);
    else if (dn) return cur - W'(1);
    else         return cur;
  endfunction

  assign ev_ovf = step_up && !clr_idx && (count == MAXV);
  assign ev_unf = step_dn && !clr_idx && (count == MINV);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= next_count(count, step_up, step_dn, clr_idx);
  end

endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import qdec_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SYNC     = 2,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_in,
  input  logic             b_in,
  input  logic             idx_in,
  input  logic             idx_en,
  input  logic             filt_en,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  logic [2:0]       clean;
  logic             valid;
  logic             step_up, step_dn, ev_bad, ev_idx, ev_ovf, ev_unf;
  logic [CNT_W-1:0] count;
  logic [ST_W-1:0]  status;
  logic [ST_W-1:0]  events;
  logic             clr;

  qdec_input_cond #(.N(3), .SYNC(SYNC), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst(rst), .filt_en(filt_en),
    .raw({idx_in, a_in, b_in}), .clean(clean), .valid(valid)
  );

  qdec_tracker u_trk (
    .clk(clk), .rst(rst), .valid(valid), .ab(clean[1:0]), .idx(clean[2]),
    .idx_en(idx_en), .step_up(step_up), .step_dn(step_dn),
    .ev_bad(ev_bad), .ev_idx(ev_idx)
  );

  qdec_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn),
    .clr_idx(ev_idx), .count(count), .ev_ovf(ev_ovf), .ev_unf(ev_unf)
  );

  always_comb begin
    events         = '0;
    events[ST_OVF] = ev_ovf;
    events[ST_UNF] = ev_unf;
    events[ST_IDX] = ev_idx;
    events[ST_BAD] = ev_bad;
  end

  assign clr = rd_en && rd_addr;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (clr ? '0 : status) | events;
  end

  assign irq     = |status;
  assign rd_data = rd_addr ? CNT_W'(status) : count;

endmodule

// File: rtl/quad_decoder_chk.sv
module quad_decoder_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] count,
  input logic [3:0]   status,
  input logic         irq,
  input logic         step_up,
  input logic         step_dn,
  input logic         ev_bad,
  input logic         ev_idx,
  input logic         ev_ovf,
  input logic         ev_unf,
  input logic         clr
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [3:0] evv;
  assign evv = {ev_bad, ev_idx, ev_unf, ev_ovf};

  assert_one_move_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step_up, step_dn, ev_bad}));

  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    (step_up && !ev_idx && !ev_ovf) |=> count == $past(count) + W'(1));

  assert_count_dn_R3: assert property (@(posedge clk) disable iff (rst)
    (step_dn && !ev_idx && !ev_unf) |=> count == $past(count) - W'(1));

  assert_bad_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_bad && !ev_idx) |=> $stable(count));

  assert_wrap_min_R5: assert property (@(posedge clk) disable iff (rst)
    ev_ovf |=> count == MINV);

  assert_wrap_max_R6: assert property (@(posedge clk) disable iff (rst)
    ev_unf |=> count == MAXV);

  assert_index_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ev_idx |=> count == '0);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (status & $past(status)) == $past(status));

  assert_event_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (|evv) |=> (status & $past(evv)) == $past(evv));

  assert_irq_pending_R10: assert property (@(posedge clk) disable iff (rst)
    (|evv) |=> irq);

endmodule

bind quad_decoder quad_decoder_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .count(count), .status(status), .irq(irq),
  .step_up(step_up), .step_dn(step_dn), .ev_bad(ev_bad), .ev_idx(ev_idx),
  .ev_ovf(ev_ovf), .ev_unf(ev_unf), .clr(clr)
);

// File: tb/tb_quad_decoder.sv
module tb_quad_decoder;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b1, b = 1'b1, idx = 1'b0;
  logic idx_en = 1'b0, filt_en = 1'b1, rd_en = 1'b0, rd_addr = 1'b0;
  logic [W-1:0] rd_data;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  int ecnt  = 0;
  logic [3:0] est = 4'h0;
  int p = 2;

  always #10 clk = ~clk;

  quad_decoder #(.CNT_W(W), .SYNC(2), .FILT_LEN(3)) dut (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .idx_in(idx), .idx_en(idx_en),
    .filt_en(filt_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic drive_ab();
    case (p)
      0: {a, b} = 2'b00;
      1: {a, b} = 2'b01;
      2: {a, b} = 2'b11;
      default: {a, b} = 2'b10;
    endcase
  endtask

  task automatic check_count(input string req);
    rd_addr = 1'b0;
    #1;
    check(req, int'(rd_data), int'(ecnt[3:0]));
  endtask

  // R11: status on rd_addr 1; optional clear strobe
  task automatic check_status(input string req, input bit do_clear);
    rd_addr = 1'b1;
    #1;
    check(req, int'(rd_data), int'(est));
    check({req, " irq R10"}, int'(irq), int'(|est));
    if (do_clear) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      est   = 4'h0;
    end
    rd_addr = 1'b0;
  endtask

  task automatic step(input bit fwd);
    p = fwd ? (p + 1) % 4 : (p + 3) % 4;
    drive_ab();
    if (fwd) begin
      if (ecnt == 7) begin ecnt = -8; est[0] = 1'b1; end
      else ecnt++;
    end else begin
      if (ecnt == -8) begin ecnt = 7; est[1] = 1'b1; end
      else ecnt--;
    end
    settle();
    check_count(fwd ? "R2 forward step" : "R3 reverse step");
  endtask

  task automatic both_pulse(input int len);
    a = ~a; b = ~b;
    repeat (len) @(negedge clk);
    a = ~a; b = ~b;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 and R12: reset with phases at 11, no spurious event
    check_count("R1 reset count");
    check_status("R1 R12 reset status", 1'b0);

    for (int f = 1; f >= 0; f--) begin
      filt_en = f[0];
      for (int i = 0; i < 20; i++) step(1'b1);
      // R5 overflow sticky (R9) after many further steps
      check_status("R5 R9 overflow", 1'b1);
      check_status("R9 cleared", 1'b0);
      for (int i = 0; i < 30; i++) step(1'b0);
      check_status("R6 underflow", 1'b1);
    end

    // R4: both phases move in one step
    filt_en = 1'b1;
    p = (p + 2) % 4;
    drive_ab();
    settle();
    est[3] = 1'b1;
    check_count("R4 count held");
    check_status("R4 invalid", 1'b1);

    // R8: 2-sample pulse dropped with filter on
    both_pulse(2);
    check_count("R8 filtered count");
    check_status("R8 short pulse dropped", 1'b0);
    // R8: 3-sample pulse accepted with filter on
    both_pulse(3);
    est[3] = 1'b1;
    check_count("R8 three-sample count");
    check_status("R8 three-sample accepted", 1'b1);
    // R8: 2-sample pulse seen with filter off
    filt_en = 1'b0;
    both_pulse(2);
    est[3] = 1'b1;
    check_count("R8 unfiltered count");
    check_status("R8 unfiltered pulse seen", 1'b1);

    // R7: index disabled then enabled
    filt_en = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1);
    idx = 1'b1; repeat (6) @(negedge clk); idx = 1'b0;
    settle();
    check_count("R7 index ignored count");
    check_status("R7 index ignored status", 1'b0);
    idx_en = 1'b1;
    idx = 1'b1; repeat (6) @(negedge clk); idx = 1'b0;
    settle();
    ecnt = 0; est[2] = 1'b1;
    check_count("R7 index clears count");
    check_status("R7 index event", 1'b1);
    step(1'b0);
    check_count("R11 negative count readout");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule